// File: doc/BRIEF.md
# Data cache line maintenance unit

This unit carries out maintenance operations on single lines of a small direct-mapped write-back data cache. A request carries an operation code, a base register number with its value, an index value and a privilege bit. The unit forms an effective address, ignores the byte offset within the 128-byte line, and looks the line up in its own tag/valid/dirty array. Depending on the operation, it writes a line back to memory, drops it, marks it clean, installs it as all zeros, or brings it in from memory. Write-backs and fills move one whole line per request/acknowledge handshake.

Each request ends in exactly one single-cycle response. The response is either done or an exception with a cause code. A storage exception is raised for addresses in unmapped pages. A privilege exception is raised for the invalidate operation when it is issued without privilege. No register result and no status flags are produced. The unit accepts a new request only while idle.

Top module: `cml_unit`

## Requirements
- R1: The effective address is base plus index modulo 2^64. The base is literal zero when `ra_sel_i` is 0, and `ra_i` otherwise.
- R2: Address bits [6:0] are ignored. Bits [9:7] pick one of 8 sets and bits [63:10] form the tag. Write-back and fill addresses are line-aligned, with bits [6:0] zero.
- R3: Flush (op 1) on a dirty hit writes the line back once and then invalidates it. On a clean hit it invalidates the line with no write-back. On a miss it does nothing.
- R4: Store-back (op 2) on a dirty hit writes the line back and leaves it valid and clean. A clean hit or a miss causes no traffic.
- R5: Invalidate (op 3), when privileged, drops a hitting line without writing it back, so dirty data is lost.
- R6: Allocate-zero (op 4) installs the line as valid, dirty and all zero without any fill. A dirty line with a different tag in that set is written back first. A clean victim is simply replaced.
- R7: Fetch (op 0) does nothing on a hit. On a miss it writes back a dirty victim, if there is one, and then fills the line from memory as valid and clean. A line removed by flush or invalidate therefore misses and refills.
- R8: For ops 0 to 4, an address is mapped only when bits [63:16] are zero and bit [15:12] of the page map is set. By default only page 14 is unmapped. An unmapped address gives a storage exception (cause 1) with no cache or memory change.
- R9: Invalidate without privilege gives a privilege exception (cause 2) with no change, and this takes priority over the storage check. All other ops behave the same whatever the privilege bit.
- R10: `busy_o` rises the cycle after a request is accepted in idle. It stays high through the response cycle. Exactly one of `done_o` or `exc_o` pulses for one cycle, and `busy_o` is low in the following cycle.
- R11: A write-back or fill request holds its address stable until acknowledged. Both requests are never active together.
- R12: Op codes 5 to 7 respond done with no cache change and no memory traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Operation request, taken when idle |
| op_i | input | 3 | Operation code |
| priv_i | input | 1 | Privileged mode |
| ra_sel_i | input | 5 | Base register number |
| ra_i | input | ADDR_W | Base register value |
| rb_i | input | ADDR_W | Index register value |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completed without exception |
| exc_o | output | 1 | Completed with exception |
| exc_cause_o | output | 2 | 1 storage, 2 privilege, 0 otherwise |
| wb_req_o | output | 1 | Line write-back request |
| wb_addr_o | output | ADDR_W | Write-back line address |
| wb_data_o | output | LINE_BYTES*8 | Write-back line data |
| wb_ack_i | input | 1 | Write-back accepted |
| fill_req_o | output | 1 | Line fill request |
| fill_addr_o | output | ADDR_W | Fill line address |
| fill_data_i | input | LINE_BYTES*8 | Fill line data |
| fill_ack_i | input | 1 | Fill data valid |

## Verification
Some properties are checked on every cycle: the response handshake, the single-pulse response, mutual exclusion of write-back and fill, and address hold until acknowledge. It is also checked every cycle that an exception cycle leaves every valid and dirty bit unchanged. Other behaviour can only be shown by the bench's operation sequences, which run against a reference model of the cache and memory. These include which line gets written back and with what data, that base register 0 reads as zero, and that an invalidated dirty line later refills with stale memory contents. They also include that a flushed line misses again and that an unused op code leaves a dirty line in place.

// File: rtl/cml_pkg.sv
package cml_pkg;
  localparam logic [2:0] OP_FETCH = 3'd0;
  localparam logic [2:0] OP_FLUSH = 3'd1;
  localparam logic [2:0] OP_STORE = 3'd2;
  localparam logic [2:0] OP_INVAL = 3'd3;
  localparam logic [2:0] OP_ZERO  = 3'd4;

  typedef enum logic [1:0] {
    EXC_NONE    = 2'd0,
    EXC_STORAGE = 2'd1,
    EXC_PRIV    = 2'd2
  } exc_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_WB, S_FILL, S_RESP
  } state_e;

  // action pending after a write-back completes
  typedef enum logic [1:0] {
    P_FILL, P_DROP, P_CLEAN, P_ZERO
  } pend_e;
endpackage

// File: rtl/cml_addr.sv
module cml_addr #(
  parameter int ADDR_W     = 64,
  parameter int OFF_W      = 7,
  parameter int IDX_W      = 3,
  parameter int PAGE_SHIFT = 12,
  parameter int PAGE_BITS  = 4,
  parameter logic [2**PAGE_BITS-1:0] PAGE_MAP = '1,
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W
) (
  input  logic [4:0]        ra_sel_i,
  input  logic [ADDR_W-1:0] ra_i,
  input  logic [ADDR_W-1:0] rb_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              mapped_o
);
  localparam int HI_LSB = PAGE_SHIFT + PAGE_BITS;

  logic [ADDR_W-1:0] ea;
  logic [ADDR_W-1:0] base;
  logic              unused_off;

  assign base  = (ra_sel_i == 5'd0) ? '0 : ra_i;
  assign ea    = base + rb_i;
  assign tag_o = ea[ADDR_W-1 -: TAG_W];
  assign idx_o = ea[OFF_W +: IDX_W];
  assign unused_off = ^ea[OFF_W-1:0];

  assign mapped_o = ~|ea[ADDR_W-1:HI_LSB] && PAGE_MAP[ea[PAGE_SHIFT +: PAGE_BITS]];
endmodule

// File: rtl/cml_tag_array.sv
module cml_tag_array #(
  parameter int SETS   = 8,
  parameter int TAG_W  = 54,
  parameter int LINE_W = 1024,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              rd_val_o,
  output logic              rd_dirty_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [LINE_W-1:0] rd_data_o,
  input  logic              we_i,
  input  logic              wr_val_i,
  input  logic              wr_dirty_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic              dwe_i,
  input  logic [LINE_W-1:0] wr_data_i,
  output logic [SETS-1:0]   val_vec_o,
  output logic [SETS-1:0]   dirty_vec_o
);
  logic [SETS-1:0]   val_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_w [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q   <= '0;
      dirty_q <= '0;
      for (int s = 0; s < SETS; s++) tag_q[s] <= '0;
    end else if (we_i) begin
      val_q[idx_i]   <= wr_val_i;
      dirty_q[idx_i] <= wr_dirty_i;
      tag_q[idx_i]   <= wr_tag_i;
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [LINE_W-1:0] line_q;
    always_ff @(posedge clk_i) begin
      if (dwe_i && idx_i == IDX_W'(s)) line_q <= wr_data_i;
    end
    assign line_w[s] = line_q;
  end

  assign rd_val_o    = val_q[idx_i];
  assign rd_dirty_o  = dirty_q[idx_i];
  assign rd_tag_o    = tag_q[idx_i];
  assign rd_data_o   = line_w[idx_i];
  assign val_vec_o   = val_q;
  assign dirty_vec_o = dirty_q;

  // R6/R7: any line marked dirty must also be valid
  a_r6_dirty_implies_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dirty_q & ~val_q) == '0);
endmodule

// File: rtl/cml_seq.sv
module cml_seq
  import cml_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 7,
  parameter int IDX_W  = 3,
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        op_i,
  input  logic              priv_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              mapped_i,
  output logic [IDX_W-1:0]  idx_o,
  input  logic              rd_val_i,
  input  logic              rd_dirty_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  output logic              we_o,
  output logic              wr_val_o,
  output logic              wr_dirty_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output logic              dwe_o,
  output logic              dzero_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              exc_o,
  output logic [1:0]        exc_cause_o,
  output logic              wb_req_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  input  logic              wb_ack_i,
  output logic              fill_req_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  input  logic              fill_ack_i
);
  state_e            st_q, st_d;
  exc_e              cause_q, cause_d;
  pend_e             pend_q, pend_d;
  logic [2:0]        op_q;
  logic              priv_q, map_q;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] wba_q, wba_d;
  logic              accept, hit, victim_dirty;
  logic [ADDR_W-1:0] own_addr, victim_addr;

  assign accept       = (st_q == S_IDLE) && req_i;
  assign hit          = rd_val_i && (rd_tag_i == tag_q);
  assign victim_dirty = rd_val_i && rd_dirty_i;
  assign own_addr     = {tag_q, idx_q, {OFF_W{1'b0}}};
  assign victim_addr  = {rd_tag_i, idx_q, {OFF_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cause_q <= EXC_NONE;
      pend_q  <= P_FILL;
      wba_q   <= '0;
      op_q    <= '0;
      priv_q  <= 1'b0;
      map_q   <= 1'b0;
      tag_q   <= '0;
      idx_q   <= '0;
    end else begin
      st_q    <= st_d;
      cause_q <= cause_d;
      pend_q  <= pend_d;
      wba_q   <= wba_d;
      if (accept) begin
        op_q   <= op_i;
        priv_q <= priv_i;
        map_q  <= mapped_i;
        tag_q  <= tag_i;
        idx_q  <= idx_i;
      end
    end
  end

  always_comb begin
    st_d       = st_q;
    cause_d    = cause_q;
    pend_d     = pend_q;
    wba_d      = wba_q;
    we_o       = 1'b0;
    wr_val_o   = 1'b0;
    wr_dirty_o = 1'b0;
    dwe_o      = 1'b0;
    dzero_o    = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (req_i) begin
          st_d    = S_LOOK;
          cause_d = EXC_NONE;
        end
      end
      S_LOOK: begin
        st_d = S_RESP;
        if (op_q == OP_INVAL && !priv_q) begin
          cause_d = EXC_PRIV;
        end else if (op_q <= OP_ZERO && !map_q) begin
          cause_d = EXC_STORAGE;
        end else begin
          case (op_q)
            OP_FETCH: begin
              if (!hit) begin
                if (victim_dirty) begin
                  wba_d  = victim_addr;
                  pend_d = P_FILL;
                  st_d   = S_WB;
                end else begin
                  st_d = S_FILL;
                end
              end
            end
            OP_FLUSH: begin
              if (hit && rd_dirty_i) begin
                wba_d  = own_addr;
                pend_d = P_DROP;
                st_d   = S_WB;
              end else if (hit) begin
                we_o = 1'b1;
              end
            end
            OP_STORE: begin
              if (hit && rd_dirty_i) begin
                wba_d  = own_addr;
                pend_d = P_CLEAN;
                st_d   = S_WB;
              end
            end
            OP_INVAL: begin
              if (hit) we_o = 1'b1;
            end
            OP_ZERO: begin
              if (victim_dirty && !hit) begin
                wba_d  = victim_addr;
                pend_d = P_ZERO;
                st_d   = S_WB;
              end else begin
                we_o       = 1'b1;
                wr_val_o   = 1'b1;
                wr_dirty_o = 1'b1;
                dwe_o      = 1'b1;
                dzero_o    = 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
      S_WB: begin
        if (wb_ack_i) begin
          st_d = S_RESP;
          unique case (pend_q)
            P_FILL:  st_d = S_FILL;
            P_DROP:  we_o = 1'b1;
            P_CLEAN: begin
              we_o     = 1'b1;
              wr_val_o = 1'b1;
            end
            P_ZERO: begin
              we_o       = 1'b1;
              wr_val_o   = 1'b1;
              wr_dirty_o = 1'b1;
              dwe_o      = 1'b1;
              dzero_o    = 1'b1;
            end
          endcase
        end
      end
      S_FILL: begin
        if (fill_ack_i) begin
          we_o     = 1'b1;
          wr_val_o = 1'b1;
          dwe_o    = 1'b1;
          st_d     = S_RESP;
        end
      end
      S_RESP:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  assign idx_o       = idx_q;
  assign wr_tag_o    = tag_q;
  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = (st_q == S_RESP) && (cause_q == EXC_NONE);
  assign exc_o       = (st_q == S_RESP) && (cause_q != EXC_NONE);
  assign exc_cause_o = (st_q == S_RESP) ? cause_q : EXC_NONE;
  assign wb_req_o    = (st_q == S_WB);
  assign wb_addr_o   = wba_q;
  assign fill_req_o  = (st_q == S_FILL);
  assign fill_addr_o = own_addr;

  a_r10_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o);
  a_r10_one_response: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, exc_o}) && ((done_o || exc_o) -> busy_o));
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || exc_o) |=> !(done_o || exc_o) && !busy_o);
  a_r11_wb_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_req_o && !wb_ack_i) |=> wb_req_o && $stable(wb_addr_o));
  a_r11_fill_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && !fill_ack_i) |=> fill_req_o && $stable(fill_addr_o));
  a_r11_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wb_req_o && fill_req_o));
  a_r9_priv_only_inval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_o && exc_cause_o == EXC_PRIV) |-> (op_q == OP_INVAL) && !priv_q);
  a_r2_wb_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o |-> (wb_addr_o[OFF_W-1:0] == '0));
endmodule

// File: rtl/cml_unit.sv
module cml_unit #(
  parameter int ADDR_W     = 64,
  parameter int SETS       = 8,
  parameter int LINE_BYTES = 128,
  parameter int PAGE_SHIFT = 12,
  parameter int PAGE_BITS  = 4,
  parameter logic [2**PAGE_BITS-1:0] PAGE_MAP = 16'hBFFF,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        op_i,
  input  logic              priv_i,
  input  logic [4:0]        ra_sel_i,
  input  logic [ADDR_W-1:0] ra_i,
  input  logic [ADDR_W-1:0] rb_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              exc_o,
  output logic [1:0]        exc_cause_o,
  output logic              wb_req_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [LINE_W-1:0] wb_data_o,
  input  logic              wb_ack_i,
  output logic              fill_req_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  input  logic [LINE_W-1:0] fill_data_i,
  input  logic              fill_ack_i
);
  logic [TAG_W-1:0]  req_tag, rd_tag, wr_tag;
  logic [IDX_W-1:0]  req_idx, arr_idx;
  logic              req_mapped;
  logic              rd_val, rd_dirty;
  logic              we, wr_val, wr_dirty, dwe, dzero;
  logic [LINE_W-1:0] rd_data;
  logic [SETS-1:0]   val_vec, dirty_vec;

  cml_addr #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
    .PAGE_SHIFT(PAGE_SHIFT), .PAGE_BITS(PAGE_BITS), .PAGE_MAP(PAGE_MAP)
  ) u_addr (
    .ra_sel_i (ra_sel_i),
    .ra_i     (ra_i),
    .rb_i     (rb_i),
    .tag_o    (req_tag),
    .idx_o    (req_idx),
    .mapped_o (req_mapped)
  );

  cml_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .op_i        (op_i),
    .priv_i      (priv_i),
    .tag_i       (req_tag),
    .idx_i       (req_idx),
    .mapped_i    (req_mapped),
    .idx_o       (arr_idx),
    .rd_val_i    (rd_val),
    .rd_dirty_i  (rd_dirty),
    .rd_tag_i    (rd_tag),
    .we_o        (we),
    .wr_val_o    (wr_val),
    .wr_dirty_o  (wr_dirty),
    .wr_tag_o    (wr_tag),
    .dwe_o       (dwe),
    .dzero_o     (dzero),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .exc_o       (exc_o),
    .exc_cause_o (exc_cause_o),
    .wb_req_o    (wb_req_o),
    .wb_addr_o   (wb_addr_o),
    .wb_ack_i    (wb_ack_i),
    .fill_req_o  (fill_req_o),
    .fill_addr_o (fill_addr_o),
    .fill_ack_i  (fill_ack_i)
  );

  cml_tag_array #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_i       (arr_idx),
    .rd_val_o    (rd_val),
    .rd_dirty_o  (rd_dirty),
    .rd_tag_o    (rd_tag),
    .rd_data_o   (rd_data),
    .we_i        (we),
    .wr_val_i    (wr_val),
    .wr_dirty_i  (wr_dirty),
    .wr_tag_i    (wr_tag),
    .dwe_i       (dwe),
    .wr_data_i   (dzero ? '0 : fill_data_i),
    .val_vec_o   (val_vec),
    .dirty_vec_o (dirty_vec)
  );

  assign wb_data_o = rd_data;

  // R8/R9: an exception response follows a cycle with no array update
  a_r8_exc_keeps_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> $stable(val_vec) && $stable(dirty_vec));
endmodule

// File: tb/tb_cml_unit.sv
module tb_cml_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] PMAP = 16'hBFFF;

  typedef struct {
    logic [63:0]   a;
    logic [1023:0] d;
  } wb_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_i = 1'b0, priv_i = 1'b0, wb_ack_i = 1'b0, fill_ack_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [4:0] ra_sel_i = '0;
  logic [63:0] ra_i = '0, rb_i = '0;
  logic [1023:0] fill_data_i = '0;
  logic busy_o, done_o, exc_o, wb_req_o, fill_req_o;
  logic [1:0] exc_cause_o;
  logic [63:0] wb_addr_o, fill_addr_o;
  logic [1023:0] wb_data_o;

  int checks = 0, fails = 0, cycles = 0, dly = 0;
  string cur_req = "R10";

  wb_t         exp_wb[$];
  logic [63:0] exp_fill[$];
  logic [1:0]  exp_resp[$];
  logic [1023:0] mem [logic [56:0]];
  logic          m_val[8], m_dirty[8];
  logic [53:0]   m_tag[8];
  logic [1023:0] m_data[8];

  always #(CLK_PERIOD/2) clk = ~clk;

  cml_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .op_i(op_i), .priv_i(priv_i),
    .ra_sel_i(ra_sel_i), .ra_i(ra_i), .rb_i(rb_i),
    .busy_o(busy_o), .done_o(done_o), .exc_o(exc_o), .exc_cause_o(exc_cause_o),
    .wb_req_o(wb_req_o), .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o), .wb_ack_i(wb_ack_i),
    .fill_req_o(fill_req_o), .fill_addr_o(fill_addr_o), .fill_data_i(fill_data_i),
    .fill_ack_i(fill_ack_i)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [1023:0] mem_rd(input logic [56:0] ln);
    if (mem.exists(ln)) return mem[ln];
    return {16{{7'd0, ln} ^ 64'h5A5A_0000_C3C3_0000}};
  endfunction

  // reference model of the requirements
  task automatic model_op(input logic [2:0] op, input logic pv, input logic [4:0] rs,
                          input logic [63:0] ra, input logic [63:0] rb);
    logic [63:0] ea;
    logic [2:0]  ix;
    logic [53:0] tg;
    logic        mapped, hit, vdirty;
    ea     = ((rs == 5'd0) ? 64'd0 : ra) + rb;
    ix     = ea[9:7];
    tg     = ea[63:10];
    mapped = (ea[63:16] == '0) && PMAP[ea[15:12]];
    hit    = m_val[ix] && (m_tag[ix] == tg);
    vdirty = m_val[ix] && m_dirty[ix];
    if (op == 3'd3 && !pv) begin
      exp_resp.push_back(2'd2);
      return;
    end
    if (op <= 3'd4 && !mapped) begin
      exp_resp.push_back(2'd1);
      return;
    end
    exp_resp.push_back(2'd0);
    case (op)
      3'd0: if (!hit) begin
        if (vdirty) begin
          exp_wb.push_back('{{m_tag[ix], ix, 7'd0}, m_data[ix]});
          mem[{m_tag[ix], ix}] = m_data[ix];
        end
        exp_fill.push_back({tg, ix, 7'd0});
        m_data[ix] = mem_rd({tg, ix});
        m_val[ix] = 1'b1; m_dirty[ix] = 1'b0; m_tag[ix] = tg;
      end
      3'd1: if (hit) begin
        if (m_dirty[ix]) begin
          exp_wb.push_back('{{tg, ix, 7'd0}, m_data[ix]});
          mem[{tg, ix}] = m_data[ix];
        end
        m_val[ix] = 1'b0; m_dirty[ix] = 1'b0;
      end
      3'd2: if (hit && m_dirty[ix]) begin
        exp_wb.push_back('{{tg, ix, 7'd0}, m_data[ix]});
        mem[{tg, ix}] = m_data[ix];
        m_dirty[ix] = 1'b0;
      end
      3'd3: if (hit) begin
        m_val[ix] = 1'b0; m_dirty[ix] = 1'b0;
      end
      3'd4: begin
        if (vdirty && !hit) begin
          exp_wb.push_back('{{m_tag[ix], ix, 7'd0}, m_data[ix]});
          mem[{m_tag[ix], ix}] = m_data[ix];
        end
        m_data[ix] = '0; m_val[ix] = 1'b1; m_dirty[ix] = 1'b1; m_tag[ix] = tg;
      end
      default: ;
    endcase
  endtask

  task automatic run_op(input logic [2:0] op, input logic pv, input logic [4:0] rs,
                        input logic [63:0] ra, input logic [63:0] rb, input string rq);
    int n;
    model_op(op, pv, rs, ra, rb);
    cur_req = rq;
    @(negedge clk);
    req_i = 1'b1; op_i = op; priv_i = pv; ra_sel_i = rs; ra_i = ra; rb_i = rb;
    @(negedge clk);
    req_i = 1'b0;
    chk(busy_o == 1'b1, "R10", "busy after accept", {63'd0, busy_o}, 64'd1);
    n = 0;
    while (!(done_o || exc_o) && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n < 100, "R10", "response timeout", 64'(n), 64'd100);
    @(negedge clk);
    chk(!busy_o && !done_o && !exc_o, "R10", "idle after response",
        {61'd0, busy_o, done_o, exc_o}, 64'd0);
    chk(exp_wb.size() == 0 && exp_fill.size() == 0 && exp_resp.size() == 0, rq,
        "pending traffic", 64'(exp_wb.size() + exp_fill.size()), 64'd0);
  endtask

  // monitor: response scoreboard
  always @(negedge clk) begin
    if (rst_n && (done_o || exc_o)) begin
      if (exp_resp.size() == 0) begin
        chk(1'b0, cur_req, "unexpected response", {62'd0, exc_cause_o}, 64'd0);
      end else begin
        logic [1:0] e;
        logic [1:0] got;
        e = exp_resp.pop_front();
        got = exc_o ? exc_cause_o : 2'd0;
        chk((done_o == (e == 2'd0)) && (got == e), (e == 2'd0) ? cur_req : (e == 2'd1 ? "R8" : "R9"),
            "response cause", {62'd0, got}, {62'd0, e});
      end
    end
  end

  // memory responder with write-back and fill scoreboard
  always @(negedge clk) begin
    if (wb_ack_i || fill_ack_i) begin
      wb_ack_i = 1'b0;
      fill_ack_i = 1'b0;
    end else if (wb_req_o) begin
      if (dly < 1) dly++;
      else begin
        dly = 0;
        if (exp_wb.size() == 0) begin
          chk(1'b0, cur_req, "unexpected write-back", wb_addr_o, 64'd0);
        end else begin
          wb_t e;
          e = exp_wb.pop_front();
          chk(wb_addr_o == e.a, "R2", "write-back address", wb_addr_o, e.a);
          chk(wb_data_o == e.d, cur_req, "write-back data", wb_data_o[63:0], e.d[63:0]);
        end
        wb_ack_i = 1'b1;
      end
    end else if (fill_req_o) begin
      if (exp_fill.size() == 0) begin
        chk(1'b0, cur_req, "unexpected fill", fill_addr_o, 64'd0);
      end else begin
        logic [63:0] e;
        e = exp_fill.pop_front();
        chk(fill_addr_o == e, "R7", "fill address", fill_addr_o, e);
      end
      fill_data_i = mem_rd(fill_addr_o[63:7]);
      fill_ack_i = 1'b1;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL R10 watchdog: actual %0d cycles expected below 150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_val[i] = 1'b0; m_dirty[i] = 1'b0; m_tag[i] = '0; m_data[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !exc_o, "R10", "reset response state",
        {61'd0, busy_o, done_o, exc_o}, 64'd0);
    chk(!wb_req_o && !fill_req_o, "R11", "reset memory requests",
        {62'd0, wb_req_o, fill_req_o}, 64'd0);

    run_op(3'd0, 1'b1, 5'd3, 64'h1000, 64'h80, "R7");        // fill 0x1080
    run_op(3'd2, 1'b0, 5'd3, 64'h1000, 64'hFF, "R4");        // clean hit, offset in line
    run_op(3'd4, 1'b0, 5'd2, 64'h1100, 64'h0, "R6");
    run_op(3'd2, 1'b0, 5'd2, 64'h1100, 64'h1, "R4");         // writes back zeros
    run_op(3'd2, 1'b0, 5'd2, 64'h1100, 64'h7F, "R2");        // now clean
    run_op(3'd4, 1'b0, 5'd1, 64'h1200, 64'h0, "R6");
    run_op(3'd1, 1'b0, 5'd1, 64'h1200, 64'h7F, "R3");        // dirty flush, unprivileged
    run_op(3'd0, 1'b0, 5'd1, 64'h1200, 64'h0, "R7");         // flushed line refills
    run_op(3'd1, 1'b0, 5'd0, 64'hDEAD_BEEF_0000_0000, 64'h1080, "R1"); // base zero, clean flush
    run_op(3'd0, 1'b0, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1080, "R1"); // refill
    run_op(3'd1, 1'b0, 5'd1, 64'h3000, 64'h0, "R3");         // flush miss
    run_op(3'd0, 1'b1, 5'd1, 64'h1080, 64'h10, "R7");        // fetch hit

    run_op(3'd4, 1'b1, 5'd1, 64'h1300, 64'h0, "R6");
    run_op(3'd3, 1'b0, 5'd1, 64'h1300, 64'h0, "R9");         // privilege exception
    run_op(3'd2, 1'b1, 5'd1, 64'h1300, 64'h0, "R9");         // line kept dirty
    run_op(3'd4, 1'b1, 5'd1, 64'h1380, 64'h0, "R6");
    run_op(3'd3, 1'b1, 5'd1, 64'h1380, 64'h0, "R5");         // drops dirty data
    run_op(3'd2, 1'b1, 5'd1, 64'h1380, 64'h0, "R5");         // miss, no traffic
    run_op(3'd0, 1'b1, 5'd1, 64'h1380, 64'h0, "R5");         // stale memory refill

    run_op(3'd4, 1'b1, 5'd1, 64'h1000, 64'h0, "R6");
    run_op(3'd4, 1'b1, 5'd1, 64'hE000, 64'h0, "R8");         // unmapped page 14
    run_op(3'd1, 1'b0, 5'd4, 64'h1_0000_0000, 64'h1000, "R8"); // high bits set
    run_op(3'd3, 1'b0, 5'd1, 64'hE000, 64'h0, "R9");         // privilege before storage
    run_op(3'd2, 1'b1, 5'd1, 64'h1000, 64'h0, "R8");         // line 0x1000 untouched

    run_op(3'd4, 1'b1, 5'd1, 64'h1500, 64'h0, "R6");         // clean victim replaced
    run_op(3'd0, 1'b1, 5'd1, 64'h1100, 64'h0, "R7");         // dirty victim then fill
    run_op(3'd4, 1'b1, 5'd1, 64'h1900, 64'h0, "R6");
    run_op(3'd4, 1'b1, 5'd1, 64'h1D00, 64'h0, "R6");         // dirty victim written back
    run_op(3'd6, 1'b0, 5'd1, 64'h1D00, 64'h0, "R12");        // unused code
    run_op(3'd7, 1'b1, 5'd1, 64'hE000, 64'h0, "R12");        // unused code, unmapped
    run_op(3'd2, 1'b1, 5'd1, 64'h1D00, 64'h0, "R12");        // still dirty afterwards

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule